// File: doc/BRIEF.md
# Up-Counting Interval Timer with Auto-Reload

This block is a general-purpose interval timer built around a wide up-counter. Software picks a delay by writing the counter with the all-ones value minus the wanted number of increments and then setting a start bit. The counter then steps once per clock. When it steps past all-ones it wraps, and that wrap is the timer event. The event sets a sticky status bit. A level interrupt follows that bit, gated by an enable bit.

With the reload bit set, every wrap copies a separately held load value into the counter, so the events repeat at a fixed period. A load value of zero with reload set makes the counter a free-running timebase that software can read at any moment. With reload clear the timer is one-shot: at the wrap the start bit drops by itself and the counter rests at zero.

A start does not take effect at once. It passes through a short pipeline of `SYNC_STAGES` flops before counting begins, and software keeps every requested delay at three counts or more to cover that latency. Stopping takes effect immediately. Software stops the timer, and leaves it stopped for a few cycles, before it programs the timer again.

Top module: `tmr_upcount`

## Requirements
- R1: After reset every register reads zero, the counter output is zero and `irq` is low.
- R2: Register map on `bus_addr`. 0x00 holds control, with bit 0 = start and bit 1 = reload. 0x04 is the load value. 0x08 is the counter, which can be read and written. 0x0C is status, bit 0 = overflow. 0x10 is the interrupt enable, bit 0. Any other address reads zero. `bus_rdata` shows the addressed register in the same cycle, and a write pulse on `bus_wr` is taken at the next rising edge.
- R3: The timer may be started only after it has been stopped for at least `SYNC_STAGES` cycles. When a start write is taken at edge E0, the counter keeps its value through edge E(SYNC_STAGES) and first increments at edge E(SYNC_STAGES+1). It then increments by one at every edge. While start is clear, the counter holds its value.
- R4: An increment from all-ones wraps the counter and sets the status bit. If the counter is written with all-ones minus N and the timer is then started, status stays clear through edge E(N+SYNC_STAGES) and is set after edge E(N+SYNC_STAGES+1).
- R5: With reload clear, the wrap clears the start bit and leaves the counter at zero, where it stays.
- R6: With reload set, the wrap loads the counter from the load register and start stays set. A load value of all-ones minus (P−1) gives one event every P cycles.
- R7: A load value of zero with start and reload set makes the counter run continuously. After the wrap it counts on from zero.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. When a wrap and a clear fall on the same edge, the bit ends up set.
- R9: `irq` is high exactly while both the status bit and the enable bit are set. Clearing the enable lowers `irq` but keeps the status bit.
- R10: A counter write takes effect at its edge, even while the timer is counting, and counting continues from the written value. A load write does not change the counter until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write pulse, taken at the rising edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt: status AND enable |
| count_out | output | CNT_W | Live counter value |

## Verification
The bench builds the timer with its defaults: a 32-bit counter and two start-sync stages. Because the counter can be written directly, a wrap is reached after only a few cycles by presetting the counter near all-ones, so one-shot, periodic and free-running behaviour can all be seen at the full width. With two sync stages, the start latency comes out at three edges. This lets the bench set a status clear on the same edge as a wrap and test which of the two wins.

// File: rtl/tmr_pkg.sv
// Package: register offsets and the control-field type shared by the
// timer's register file, its checker and its bench.
package tmr_pkg;

    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STS  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h10;

    // Control word layout: bit 1 reload, bit 0 start
    typedef struct packed {
        logic reload;
        logic start;
    } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Register file of the timer.
// Decodes single-cycle writes and holds control, load value and interrupt
// enable. It hands counter writes and status clears to the neighbouring
// blocks and serves a combinational read mux. It assumes a write is a one-
// cycle pulse on bus_wr. A control write beats the one-shot self-clear.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      cnt_val,
    input  logic              sts,
    input  logic              ovf,
    output ctrl_t             ctrl_q,
    output logic [W-1:0]      load_q,
    output logic              ien_q,
    output logic              cnt_wr,
    output logic              sts_clr
);

    logic wr_ctrl;
    logic wr_load;
    logic wr_ien;

    // Address decode of the write pulse
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_load = bus_wr && (bus_addr == OFS_LOAD);
        wr_ien  = bus_wr && (bus_addr == OFS_IEN);
        cnt_wr  = bus_wr && (bus_addr == OFS_CNT);
        sts_clr = bus_wr && (bus_addr == OFS_STS) && bus_wdata[0];
    end

    // Control register; a wrap without reload drops start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata[1:0]);
        end else if (ovf && !ctrl_q.reload) begin
            ctrl_q.start <= 1'b0;
        end
    end

    // Load value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (wr_load) begin
            load_q <= bus_wdata;
        end
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (wr_ien) begin
            ien_q <= bus_wdata[0];
        end
    end

    // Read mux; unmapped addresses return zero
    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = W'(ctrl_q);
            OFS_LOAD: bus_rdata = load_q;
            OFS_CNT:  bus_rdata = cnt_val;
            OFS_STS:  bus_rdata = W'(sts);
            OFS_IEN:  bus_rdata = W'(ien_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
// Counting core of the timer.
// Passes the start bit through SYNC_STAGES flops before counting may begin.
// Stopping is immediate, because the delayed start is ANDed with the live
// one. It assumes the timer has been idle for SYNC_STAGES cycles before a
// restart. A wrap is flagged for one cycle as ovf. A counter write has
// priority over the reload and the increment.
module tmr_core #(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] count,
    output logic         run,
    output logic         ovf
);

    logic armed;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign armed = start;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            // Start-latency pipeline
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= (sync_q << 1) | SYNC_STAGES'(start);
                end
            end
            assign armed = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Run qualifier and wrap detect
    always_comb begin
        run = armed && start;
        ovf = run && (count == '1);
    end

    // Counter: write, else reload/zero on wrap, else step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= cnt_wdata;
        end else if (ovf) begin
            count <= reload ? load_val : '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_irq.sv
// Overflow status and interrupt level.
// The status bit is sticky and is cleared by a write-one. A wrap on the same
// edge as a clear wins. The interrupt is the status gated by the enable and
// holds until software clears the status.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic sts_clr,
    input  logic ien,
    output logic sts,
    output logic irq
);

    // Sticky overflow status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (ovf) begin
            sts <= 1'b1;
        end else if (sts_clr) begin
            sts <= 1'b0;
        end
    end

    // Interrupt level
    always_comb begin
        irq = sts && ien;
    end

endmodule

// File: rtl/tmr_upcount.sv
// Top of the up-counting interval timer.
// Wires the register file, the counting core and the status/interrupt
// logic together. The counter width is CNT_W, which is also the data-bus
// width. SYNC_STAGES sets the start latency.
module tmr_upcount
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq,
    output logic [CNT_W-1:0]  count_out
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic             ien_q;
    logic             cnt_wr;
    logic             sts_clr;
    logic             sts;
    logic             core_run;
    logic             core_ovf;
    logic             start_q;
    logic             reload_q;

    assign start_q  = ctrl_q.start;
    assign reload_q = ctrl_q.reload;

    tmr_regs #(.W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (count_out),
        .sts       (sts),
        .ovf       (core_ovf),
        .ctrl_q    (ctrl_q),
        .load_q    (load_q),
        .ien_q     (ien_q),
        .cnt_wr    (cnt_wr),
        .sts_clr   (sts_clr)
    );

    tmr_core #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .reload    (reload_q),
        .load_val  (load_q),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (bus_wdata),
        .count     (count_out),
        .run       (core_run),
        .ovf       (core_ovf)
    );

    tmr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (core_ovf),
        .sts_clr (sts_clr),
        .ien     (ien_q),
        .sts     (sts),
        .irq     (irq)
    );

endmodule

// File: rtl/tmr_upcount_chk.sv
// Checker for the timer, bound to the top.
// It decodes the bus writes itself and relates counter, control and status
// over time.
module tmr_upcount_chk
    import tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              run,
    input logic              ovf,
    input logic              start,
    input logic              reload,
    input logic [W-1:0]      load_val,
    input logic [W-1:0]      count,
    input logic              sts,
    input logic              irq
);

    logic c_ctrl_wr;
    logic c_cnt_wr;
    logic c_clr;
    logic c_ien_off;

    always_comb begin
        c_ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
        c_cnt_wr  = bus_wr && (bus_addr == OFS_CNT);
        c_clr     = bus_wr && (bus_addr == OFS_STS) && bus_wdata[0];
        c_ien_off = bus_wr && (bus_addr == OFS_IEN) && !bus_wdata[0];
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !ovf && !c_cnt_wr |=> count == W'($past(count) + 1'b1)); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !c_cnt_wr |=> $stable(count)); // R3
    AST_NO_OVERFLOW_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> sts); // R4
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !reload && !c_ctrl_wr && !c_cnt_wr |=> !start && count == '0); // R5
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && reload && !c_cnt_wr |=> count == $past(load_val)); // R6
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts && !c_clr |=> sts); // R8
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr && !ovf |=> !sts); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !c_clr && !c_ien_off |=> irq); // R9
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        c_cnt_wr |=> count == $past(bus_wdata)); // R10

endmodule

bind tmr_upcount tmr_upcount_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (core_run),
    .ovf       (core_ovf),
    .start     (start_q),
    .reload    (reload_q),
    .load_val  (load_q),
    .count     (count_out),
    .sts       (sts),
    .irq       (irq)
);

// File: tb/tmr_upcount_tb.sv
// Bench for the timer: a vector table of delays and modes walked by one
// loop, then directed tests for reset, registers, interrupt and corners.
module tmr_upcount_tb;
    import tmr_pkg::*;

    localparam int unsigned W    = 32;
    localparam int unsigned SYNC = 2;
    localparam logic [W-1:0] ONES = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic              irq;
    logic [W-1:0]      count_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Table entries: {reload, N}; the delay preset is all-ones minus N
    localparam logic [32:0] VECS [6] = '{
        {1'b0, 32'd0}, {1'b0, 32'd3}, {1'b0, 32'd7},
        {1'b0, 32'd20}, {1'b1, 32'd3}, {1'b1, 32'd9}
    };

    tmr_upcount #(.CNT_W(W), .SYNC_STAGES(SYNC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .count_out (count_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the next rising edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] v0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(OFS_CTRL, v); chk("R1", "ctrl after reset", v, '0);
        rd(OFS_LOAD, v); chk("R1", "load after reset", v, '0);
        rd(OFS_CNT,  v); chk("R1", "counter after reset", v, '0);
        rd(OFS_STS,  v); chk("R1", "status after reset", v, '0);
        rd(OFS_IEN,  v); chk("R1", "enable after reset", v, '0);
        chk("R1", "irq after reset", W'(irq), '0);
        chk("R1", "count_out after reset", count_out, '0);

        // R2: register access
        wr(OFS_LOAD, 32'h1234_5678);
        rd(OFS_LOAD, v); chk("R2", "load readback", v, 32'h1234_5678);
        wr(OFS_CTRL, 32'h2);
        rd(OFS_CTRL, v); chk("R2", "ctrl reload bit", v, 32'h2);
        wr(OFS_CTRL, 32'h0);
        wr(OFS_IEN, 32'hFFFF_FFFF);
        rd(OFS_IEN, v); chk("R2", "enable only bit 0", v, 32'h1);
        wr(OFS_IEN, 32'h0);
        rd(5'h14, v); chk("R2", "unmapped address", v, '0);
        rd(5'h1C, v); chk("R2", "unmapped address 2", v, '0);

        // Vector table: one-shot (R4, R5) and periodic (R6)
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] n;
            logic ar;
            n  = VECS[i][31:0];
            ar = VECS[i][32];
            wr(OFS_CTRL, 32'h0);
            idle(SYNC + 1);
            wr(OFS_STS, 32'h1);
            if (ar) wr(OFS_LOAD, ONES - n);
            wr(OFS_CNT, ONES - n);
            wr(OFS_CTRL, {30'd0, ar, 1'b1});
            idle(int'(n) + SYNC);
            rd(OFS_STS, v); chk("R4", "status before wrap", v, '0);
            rd(OFS_CNT, v); chk("R4", "counter at all-ones", v, ONES);
            idle(1);
            rd(OFS_STS, v); chk("R4", "status after wrap", v, 32'h1);
            if (!ar) begin
                rd(OFS_CNT, v);  chk("R5", "one-shot counter zero", v, '0);
                rd(OFS_CTRL, v); chk("R5", "one-shot start cleared", v, '0);
                idle(2);
                rd(OFS_CNT, v);  chk("R5", "one-shot counter holds", v, '0);
            end else begin
                rd(OFS_CNT, v);  chk("R6", "reloaded value", v, ONES - n);
                rd(OFS_CTRL, v); chk("R6", "start kept", v, 32'h3);
                wr(OFS_STS, 32'h1);
                idle(int'(n) - 1);
                rd(OFS_STS, v); chk("R6", "no event before period", v, '0);
                idle(1);
                rd(OFS_STS, v); chk("R6", "event at period", v, 32'h1);
            end
        end

        // R3: start latency and immediate stop
        wr(OFS_CTRL, 32'h0);
        idle(SYNC + 1);
        wr(OFS_STS, 32'h1);
        wr(OFS_CNT, 32'd100);
        wr(OFS_CTRL, 32'h1);
        idle(SYNC);
        rd(OFS_CNT, v); chk("R3", "no step during latency", v, 32'd100);
        idle(1);
        rd(OFS_CNT, v); chk("R3", "first step", v, 32'd101);
        idle(4);
        rd(OFS_CNT, v); chk("R3", "steady stepping", v, 32'd105);
        wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v0); chk("R3", "last step at stop edge", v0, 32'd106);
        idle(3);
        rd(OFS_CNT, v); chk("R3", "held while stopped", v, v0);

        // R7: free-running with zero load
        idle(SYNC);
        wr(OFS_LOAD, 32'h0);
        wr(OFS_CNT, 32'hFFFF_FFFE);
        wr(OFS_CTRL, 32'h3);
        idle(SYNC + 3);
        rd(OFS_CNT, v);  chk("R7", "counts on from zero", v, 32'd1);
        rd(OFS_CTRL, v); chk("R7", "still running", v, 32'h3);
        rd(OFS_STS, v);  chk("R7", "wrap flagged", v, 32'h1);

        // R10: counter write while running, load write has no effect
        wr(OFS_CNT, 32'd500);
        rd(OFS_CNT, v); chk("R10", "written value taken", v, 32'd500);
        idle(1);
        rd(OFS_CNT, v); chk("R10", "counts from written value", v, 32'd501);
        wr(OFS_LOAD, 32'd7);
        rd(OFS_CNT, v); chk("R10", "load write leaves counter", v, 32'd502);

        // R8/R9: status clear and interrupt gating
        wr(OFS_CTRL, 32'h0);
        idle(SYNC + 1);
        wr(OFS_IEN, 32'h1);
        chk("R9", "irq with status and enable", W'(irq), 32'h1);
        wr(OFS_STS, 32'h0);
        rd(OFS_STS, v); chk("R8", "write 0 keeps status", v, 32'h1);
        wr(OFS_IEN, 32'h0);
        chk("R9", "irq masked", W'(irq), '0);
        rd(OFS_STS, v); chk("R9", "mask keeps status", v, 32'h1);
        wr(OFS_IEN, 32'h1);
        chk("R9", "irq back on enable", W'(irq), 32'h1);
        wr(OFS_STS, 32'h1);
        chk("R8", "irq low after clear", W'(irq), '0);
        rd(OFS_STS, v); chk("R8", "status cleared", v, '0);

        // R8: wrap on the same edge as a clear, wrap wins
        wr(OFS_CNT, ONES - 32'd3);
        wr(OFS_CTRL, 32'h1);
        idle(3 + SYNC);
        wr(OFS_STS, 32'h1);
        rd(OFS_STS, v); chk("R8", "wrap beats clear", v, 32'h1);
        chk("R9", "irq from wrap", W'(irq), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule